// File: doc/BRIEF.md
# Dual Output Divider with Power-Down Sequencing

This block takes one fast clock from a frequency synthesizer's oscillator and produces two output clocks. Each output has its own integer divide ratio. Both ratios come from one of two stored configuration records. A select input chooses the record. Odd ratios use both edges of the input clock, so the output duty cycle stays as close to half as the ratio allows.

A power-down input, active low, stops both outputs, drops the output enable and tells the synthesizer loops to shut off. When power-down is released, the loops are enabled at once. The outputs stay disabled for a settle interval counted in input-clock cycles, and each record carries a spread flag that picks one of two interval lengths. Both asynchronous inputs pass through two-flop synchronizers before they reach the sequencing logic.

A change of the select input while running is held back until both outputs are in their low phase. Both dividers then restart together on the new ratios, so no shortened high pulse reaches a pin.

Top module: `dual_div_pwr`

## Requirements
- R1: While `rst_n` is low, `pll_en`, `out_en` and both bits of `clk_out` are 0.
- R2: With ratio N in 2..20, an enabled output repeats every N input-clock periods and is high for N/2 periods; for odd N this is a half-period step, made with the falling edge. Bank 0's ratio is record bits [4:0], bank 1's is bits [9:5].
- R3: A ratio field below 2 is used as 2, and a field above 20 is used as 20.
- R4: `cfg_sel` at 1, which is the level a floating pin is pulled to, selects record `cfg_set_a`; at 0 it selects `cfg_set_b`. While the block is powered down, the selection follows `cfg_sel` without waiting for any output phase.
- R5: A change of `cfg_sel` while outputs run keeps `out_en` high, waits for both outputs to be low, then restarts both banks so that later periods match the new record.
- R6: When `pwr_dn_n` is driven low just after a rising edge, `pll_en` and `out_en` are 0 after the third following rising edge and stay 0 while it remains low. An `out_en` fall always follows a low `pwr_dn_n` seen three edges earlier.
- R7: When `pwr_dn_n` is driven high just after a rising edge, `pll_en` is 1 after the third rising edge. `out_en` rises after edge 3+L, where L is `SETTLE_SPREAD` if bit [10] of the selected record is 1 and `SETTLE_PLAIN` if it is 0.
- R8: `out_en` is never 1 while `pll_en` is 0, and `clk_out` is 0 whenever `out_en` is 0.
- R9: No output stays high for more than (20+1)/2 consecutive rising-edge samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate clock being divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down, active low |
| cfg_sel | input | 1 | Record select: 1 = set A, 0 = set B |
| cfg_set_a | input | 11 | Record A: [4:0] bank 0 ratio, [9:5] bank 1 ratio, [10] spread flag |
| cfg_set_b | input | 11 | Record B, same layout |
| clk_out | output | 2 | Divided clocks, one bit per bank, 0 when disabled |
| out_en | output | 1 | Output enable; pads drive only while 1 |
| pll_en | output | 1 | Enable for the synthesizer loops |

## Verification
The properties assume that `clk_vco` keeps running during power-down and that both configuration records stay still while outputs run. The stimulus only rewrites the records while `pwr_dn_n` is low. It moves the asynchronous inputs half a nanosecond after a rising edge, so every synchronizer stage takes a defined value and the edge counts in R6 and R7 are exact. Random ratios, including values outside 2..20, spread flags and select levels are mixed with directed cases for the extreme ratios, an odd ratio, and a select change while running.

// File: rtl/dual_div_pkg.sv
`timescale 1ns/1ps
package dual_div_pkg;
    localparam int NUM_OUT = 2;
    localparam int DIV_W   = 5;
    localparam int DIV_LO  = 2;
    localparam int DIV_HI  = 20;
    localparam int CFG_W   = NUM_OUT * DIV_W + 1;
    localparam int SPREAD_BIT = NUM_OUT * DIV_W;
    localparam int HIGH_RUN_MAX = (DIV_HI + 1) / 2;

    typedef enum logic [1:0] {
        PD_OFF    = 2'd0,
        PD_SETTLE = 2'd1,
        PD_RUN    = 2'd2
    } pd_state_e;

    // Map a raw ratio field into the legal divide range.
    function automatic logic [DIV_W-1:0] clamp_ratio(input logic [DIV_W-1:0] raw);
        if (raw < DIV_W'(DIV_LO))
            return DIV_W'(DIV_LO);
        else if (raw > DIV_W'(DIV_HI))
            return DIV_W'(DIV_HI);
        else
            return raw;
    endfunction
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= {2{RST_VAL}};
        else
            stage_q <= stage_d;
    end

    assign q = stage_q[1];
endmodule

// File: rtl/pd_seq.sv
`timescale 1ns/1ps
module pd_seq
    import dual_div_pkg::*;
#(
    parameter int SETTLE_PLAIN  = 16,
    parameter int SETTLE_SPREAD = 64,
    parameter int CNT_W = $clog2(((SETTLE_SPREAD > SETTLE_PLAIN) ? SETTLE_SPREAD : SETTLE_PLAIN) + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic spread_on,
    output logic pll_en,
    output logic run
);
    localparam logic [CNT_W-1:0] LAST_PLAIN  = CNT_W'(SETTLE_PLAIN - 1);
    localparam logic [CNT_W-1:0] LAST_SPREAD = CNT_W'(SETTLE_SPREAD - 1);

    typedef struct packed {
        pd_state_e        st;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s s_d, s_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        s_d      = s_q;
        last_cnt = spread_on ? LAST_SPREAD : LAST_PLAIN;
        case (s_q.st)
            PD_OFF: begin
                s_d.cnt = '0;
                if (pwr_ok)
                    s_d.st = PD_SETTLE;
            end
            PD_SETTLE: begin
                if (!pwr_ok) begin
                    s_d.st  = PD_OFF;
                    s_d.cnt = '0;
                end else if (s_q.cnt == last_cnt) begin
                    s_d.st  = PD_RUN;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PD_RUN: begin
                s_d.cnt = '0;
                if (!pwr_ok)
                    s_d.st = PD_OFF;
            end
            default: begin
                s_d.st  = PD_OFF;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{st: PD_OFF, cnt: '0};
        else
            s_q <= s_d;
    end

    assign pll_en = (s_q.st != PD_OFF);
    assign run    = (s_q.st == PD_RUN);
endmodule

// File: rtl/div_bank.sv
`timescale 1ns/1ps
module div_bank
    import dual_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] ratio,
    output logic             clk_o,
    output logic             low_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             rise;
        logic             arm;
    } bank_s;

    bank_s b_d, b_q;
    logic  fall_q;
    logic [DIV_W:0] high_len;

    always_comb begin
        b_d      = b_q;
        high_len = ({1'b0, ratio} + 1'b1) >> 1;
        if (!run || restart) begin
            b_d.cnt  = '0;
            b_d.rise = 1'b0;
            b_d.arm  = 1'b1;
        end else if (b_q.arm) begin
            b_d.cnt  = '0;
            b_d.rise = 1'b1;
            b_d.arm  = 1'b0;
        end else begin
            if (b_q.cnt >= ratio - 1'b1)
                b_d.cnt = '0;
            else
                b_d.cnt = b_q.cnt + 1'b1;
            b_d.rise = ({1'b0, b_d.cnt} < high_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            b_q <= '{cnt: '0, rise: 1'b0, arm: 1'b1};
        else
            b_q <= b_d;
    end

    // Half-period delayed copy of the rising-edge phase, used to trim odd ratios.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            fall_q <= 1'b0;
        else
            fall_q <= b_q.rise;
    end

    assign clk_o = ratio[0] ? (b_q.rise & fall_q) : b_q.rise;
    assign low_o = !b_q.rise && !fall_q;
endmodule

// File: rtl/dual_div_pwr.sv
`timescale 1ns/1ps
module dual_div_pwr
    import dual_div_pkg::*;
#(
    parameter int SETTLE_PLAIN  = 800000,
    parameter int SETTLE_SPREAD = 2800000
) (
    input  logic               clk_vco,
    input  logic               rst_n,
    input  logic               pwr_dn_n,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_set_a,
    input  logic [CFG_W-1:0]   cfg_set_b,
    output logic [NUM_OUT-1:0] clk_out,
    output logic               out_en,
    output logic               pll_en
);
    localparam int SETTLE_MAX = (SETTLE_SPREAD > SETTLE_PLAIN) ? SETTLE_SPREAD : SETTLE_PLAIN;
    localparam int CNT_W      = $clog2(SETTLE_MAX + 1);

    typedef struct packed {
        logic use_a;
    } top_s;

    top_s t_d, t_q;

    logic               pwr_ok;
    logic               sel_a;
    logic               run;
    logic               restart;
    logic [CFG_W-1:0]   active_rec;
    logic [NUM_OUT-1:0] bank_clk;
    logic [NUM_OUT-1:0] bank_low;
    logic [DIV_W-1:0]   ratio [NUM_OUT];

    bit_sync #(.RST_VAL(1'b0)) u_pwr_sync (
        .clk   (clk_vco),
        .rst_n (rst_n),
        .d     (pwr_dn_n),
        .q     (pwr_ok)
    );

    bit_sync #(.RST_VAL(1'b1)) u_sel_sync (
        .clk   (clk_vco),
        .rst_n (rst_n),
        .d     (cfg_sel),
        .q     (sel_a)
    );

    assign active_rec = t_q.use_a ? cfg_set_a : cfg_set_b;

    pd_seq #(
        .SETTLE_PLAIN  (SETTLE_PLAIN),
        .SETTLE_SPREAD (SETTLE_SPREAD),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk       (clk_vco),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .spread_on (active_rec[SPREAD_BIT]),
        .pll_en    (pll_en),
        .run       (run)
    );

    // Switch records while running only when every bank sits in its low phase.
    assign restart = run && (sel_a != t_q.use_a) && (&bank_low);

    always_comb begin
        t_d = t_q;
        if (!pll_en || restart)
            t_d.use_a = sel_a;
    end

    always_ff @(posedge clk_vco or negedge rst_n) begin
        if (!rst_n)
            t_q <= '{use_a: 1'b1};
        else
            t_q <= t_d;
    end

    for (genvar b = 0; b < NUM_OUT; b++) begin : g_bank
        assign ratio[b] = clamp_ratio(active_rec[b*DIV_W +: DIV_W]);

        div_bank u_div (
            .clk     (clk_vco),
            .rst_n   (rst_n),
            .run     (run),
            .restart (restart),
            .ratio   (ratio[b]),
            .clk_o   (bank_clk[b]),
            .low_o   (bank_low[b])
        );

        assign clk_out[b] = run & bank_clk[b];
    end

    assign out_en = run;
endmodule

// File: rtl/dual_div_pwr_chk.sv
`timescale 1ns/1ps
module dual_div_pwr_chk
    import dual_div_pkg::*;
(
    input logic               clk_vco,
    input logic               rst_n,
    input logic               pwr_dn_n,
    input logic [NUM_OUT-1:0] clk_out,
    input logic               out_en,
    input logic               pll_en
);
    logic [4:0] hi_run_q [NUM_OUT];

    for (genvar b = 0; b < NUM_OUT; b++) begin : g_run
        always_ff @(posedge clk_vco or negedge rst_n) begin
            if (!rst_n)
                hi_run_q[b] <= '0;
            else if (clk_out[b])
                hi_run_q[b] <= (hi_run_q[b] == 5'd31) ? 5'd31 : hi_run_q[b] + 5'd1;
            else
                hi_run_q[b] <= '0;
        end

        // R9
        high_run_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
            clk_out[b] |-> (hi_run_q[b] < 5'(HIGH_RUN_MAX)));
    end

    // R8
    oe_needs_pll_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        out_en |-> pll_en);

    // R8
    quiet_when_off_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        !out_en |-> (clk_out == '0));

    // R6
    pd_stops_pll_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (!pwr_dn_n && !$past(pwr_dn_n) && !$past(pwr_dn_n, 2)) |=> !pll_en);

    // R6
    oe_fall_cause_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $fell(out_en) |-> !$past(pwr_dn_n, 3));

    // R7
    oe_rise_after_pll_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $rose(out_en) |-> $past(pll_en));

    // R1
    always @(negedge clk_vco) begin
        if (!rst_n)
            reset_quiet_chk: assert (!pll_en && !out_en && clk_out == '0);
    end
endmodule

bind dual_div_pwr dual_div_pwr_chk u_chk (
    .clk_vco  (clk_vco),
    .rst_n    (rst_n),
    .pwr_dn_n (pwr_dn_n),
    .clk_out  (clk_out),
    .out_en   (out_en),
    .pll_en   (pll_en)
);

// File: tb/dual_div_pwr_test.sv
`timescale 1ns/1ps
module dual_div_pwr_test;
    localparam int PLAIN  = 20;
    localparam int SPREAD = 45;

    logic        clk_vco = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn_n = 1'b0;
    logic        cfg_sel = 1'b1;
    logic [10:0] cfg_set_a = '0;
    logic [10:0] cfg_set_b = '0;
    logic [1:0]  clk_out;
    logic        out_en;
    logic        pll_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    dual_div_pwr #(.SETTLE_PLAIN(PLAIN), .SETTLE_SPREAD(SPREAD)) uut (
        .clk_vco   (clk_vco),
        .rst_n     (rst_n),
        .pwr_dn_n  (pwr_dn_n),
        .cfg_sel   (cfg_sel),
        .cfg_set_a (cfg_set_a),
        .cfg_set_b (cfg_set_b),
        .clk_out   (clk_out),
        .out_en    (out_en),
        .pll_en    (pll_en)
    );

    always #2.5 clk_vco = ~clk_vco;

    always @(posedge clk_vco) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int eff_ratio(input int raw);
        if (raw < 2) return 2;
        if (raw > 20) return 20;
        return raw;
    endfunction

    function automatic logic [10:0] make_rec(input int r0, input int r1, input bit spread);
        return {spread, 5'(r1), 5'(r0)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic drive_step();
        @(posedge clk_vco);
        #0.5;
    endtask

    // Measures one full period and its high time in half-cycle samples.
    task automatic measure(input int b, output int hi, output int per);
        bit prev, cur, nx, found, fin;
        @(posedge clk_vco);
        #1.25;
        prev = clk_out[b];
        found = 1'b0;
        cur = prev;
        for (int i = 0; i < 200 && !found; i++) begin
            #2.5;
            cur = clk_out[b];
            if (!prev && cur) found = 1'b1;
            prev = cur;
        end
        hi = 0;
        per = 0;
        fin = 1'b0;
        for (int i = 0; i < 200 && !fin && found; i++) begin
            if (cur) hi++;
            per++;
            #2.5;
            nx = clk_out[b];
            if (!cur && nx) fin = 1'b1;
            cur = nx;
        end
    endtask

    task automatic check_ratios(input string req, input int n0, input int n1);
        int hi, per;
        measure(0, hi, per);
        check({req, " bank0 period"}, per, 2 * n0);
        check({req, " bank0 high"}, hi, n0);
        measure(1, hi, per);
        check({req, " bank1 period"}, per, 2 * n1);
        check({req, " bank1 high"}, hi, n1);
    endtask

    task automatic power_down();
        int n_pll, n_oe;
        drive_step();
        pwr_dn_n = 1'b0;
        n_pll = 0;
        n_oe = 0;
        for (int n = 1; n <= 6; n++) begin
            @(posedge clk_vco);
            #1.25;
            if (n_pll == 0 && !pll_en) n_pll = n;
            if (n_oe == 0 && !out_en) n_oe = n;
        end
        // R6
        check("R6 pll_en drop edge", n_pll, 3);
        check("R6 out_en drop edge", n_oe, 3);
        check("R8 outputs low when disabled", int'(clk_out), 0);
    endtask

    task automatic power_up(input int settle);
        int n_pll, n_oe;
        drive_step();
        pwr_dn_n = 1'b1;
        n_pll = 0;
        n_oe = 0;
        for (int n = 1; n <= 4000 && n_oe == 0; n++) begin
            @(posedge clk_vco);
            #1.25;
            if (n_pll == 0 && pll_en) n_pll = n;
            if (out_en) n_oe = n;
            else if (clk_out != 2'b00) begin
                checks++;
                fails++;
                $display("FAIL R8: act=%0d exp=0 while disabled", clk_out);
            end
        end
        // R7
        check("R7 pll_en rise edge", n_pll, 3);
        check("R7 out_en rise edge", n_oe, settle + 3);
    endtask

    initial begin
        int r0, r1, r2, r3;
        bit sp, sl;
        void'($urandom(32'd20250));

        repeat (3) @(posedge clk_vco);
        #1.25;
        // R1
        check("R1 pll_en in reset", int'(pll_en), 0);
        check("R1 out_en in reset", int'(out_en), 0);
        check("R1 clk_out in reset", int'(clk_out), 0);

        drive_step();
        rst_n = 1'b1;
        cfg_set_a = make_rec(4, 7, 1'b0);
        cfg_set_b = make_rec(5, 12, 1'b1);
        cfg_sel = 1'b1;
        repeat (3) drive_step();
        // R4 R7: set A selected, spread flag clear
        power_up(PLAIN);
        // R2
        check_ratios("R2 even/odd", 4, 7);

        // R5: select switch while running
        drive_step();
        cfg_sel = 1'b0;
        repeat (60) @(posedge clk_vco);
        #1.25;
        check("R5 out_en kept", int'(out_en), 1);
        check_ratios("R5 after switch", 5, 12);

        // R4 R7: set B carries the spread flag
        power_down();
        repeat (4) drive_step();
        power_up(SPREAD);
        check_ratios("R4 set B", 5, 12);

        // R2 R3: extreme and clamped ratios
        power_down();
        cfg_set_a = make_rec(2, 20, 1'b0);
        cfg_set_b = make_rec(0, 31, 1'b0);
        cfg_sel = 1'b1;
        repeat (4) drive_step();
        power_up(PLAIN);
        check_ratios("R2 limits", 2, 20);
        power_down();
        cfg_sel = 1'b0;
        repeat (4) drive_step();
        power_up(PLAIN);
        check_ratios("R3 clamp", 2, 20);

        // Random records and selections
        for (int it = 0; it < 8; it++) begin
            power_down();
            r0 = int'($urandom_range(0, 31));
            r1 = int'($urandom_range(0, 31));
            r2 = int'($urandom_range(0, 31));
            r3 = int'($urandom_range(0, 31));
            sp = 1'($urandom_range(0, 1));
            sl = 1'($urandom_range(0, 1));
            cfg_set_a = make_rec(r0, r1, sp);
            cfg_set_b = make_rec(r2, r3, !sp);
            cfg_sel = sl;
            repeat (4) drive_step();
            power_up((sl ? sp : !sp) ? SPREAD : PLAIN);
            if (sl)
                check_ratios("R3 random A", eff_ratio(r0), eff_ratio(r1));
            else
                check_ratios("R4 random B", eff_ratio(r2), eff_ratio(r3));
        end

        power_down();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule